// File: doc/BRIEF.md
# Four-Lane Transposed Constant-Coefficient FIR Filter

This block is an eight-tap low-pass FIR filter that accepts four new input samples per clock and returns four filtered samples per clock. Its coefficients are hard-wired as h = {-3, 5, 18, 44, 44, 18, 5, -3}, so it needs neither multipliers nor a coefficient store. Each product is built from shifts, additions and subtractions of the input. Each distinct sample in the current seven-sample window (three samples kept from the previous block plus the four new ones) drives one shift-and-add network. That network produces the sample's x3, x5, x18 and x44 multiples. The partial products 9x and 11x share one shifted term, and 11x reuses 3x.

The taps are split into a leading group {h0..h3} and a trailing group {h4..h7}. For each output lane, an inner-product row forms two values: the leading-group sum for the current block, and the trailing-group sum that the next block will need. A pipelined adder stage adds each leading sum to the trailing sum held from the previous accepted block. This is the transpose-form delay. The result is produced at full 23-bit precision, with no rounding.

The filter advances only on cycles where the input strobe is high. Idle cycles neither shift in zeros nor disturb the history. A synchronous reset clears all history.

Top module: `blkfir_top`

## Requirements
- R1: For every cycle with `in_vld` high, `out_vld` is high exactly two clock cycles later. `out_vld` is never high at any other time.
- R2: Lane j of `in_blk` (bits [12j+11:12j]) carries sample x(4k+j). Lane 0 is the earliest sample. Lane j of `out_blk` (bits [23j+22:23j]) carries y(4k+j) = sum over i=0..7 of h[i]·x(4k+j−i), with h = {-3, 5, 18, 44, 44, 18, 5, -3}.
- R3: Inputs are 12-bit two's complement and outputs are 23-bit two's complement at full precision. Extreme inputs (all −2048, all +2047, alternating) give exact results, and no output exceeds 140·2048 in magnitude.
- R4: Outputs that depend on up to seven earlier samples use the correct samples from the one or two previously accepted blocks.
- R5: Cycles with `in_vld` low do not advance the filter. Data on `in_blk` during those cycles has no effect on any later output, and the next accepted block continues from the last accepted one.
- R6: While `out_vld` is low, `out_blk` holds its last value.
- R7: Synchronous active-high reset clears `out_vld` and `out_blk` to zero and clears the sample history. The first block after reset is filtered as if all earlier samples were zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input block strobe |
| in_blk | input | 48 | Four 12-bit signed samples, lane 0 earliest |
| out_vld | output | 1 | Output block strobe |
| out_blk | output | 92 | Four 23-bit signed filtered samples, lane 0 earliest |

## Verification
The assertions assume that `in_vld` stays low while reset is held, and that reset lasts at least two cycles, so that the two-cycle strobe relation and the hold check begin from cleared state. The overflow bound assumes that every input lane is a legal 12-bit two's complement value; any value of the 12-bit port satisfies this, so full-scale patterns are applied directly. The stimulus drives random data on `in_blk` during idle cycles to exercise the ignore rule, and it never raises the strobe while reset is asserted.

// File: rtl/blkfir_pkg.sv
package blkfir_pkg;
    localparam int LANES = 4;
    localparam int NTAP  = 2 * LANES;
    localparam int WIN   = 2 * LANES - 1;
    localparam int SW    = 12;
    localparam int CW    = 8;
    localparam int GW    = $clog2(NTAP);
    localparam int AW    = SW + CW + GW;
    localparam int HABS  = 140;

    typedef logic signed [SW-1:0] smp_t;
    typedef logic signed [AW-1:0] acc_t;

    typedef struct packed {
        smp_t [LANES-2:0] hist;
        logic             vld1;
        acc_t [LANES-1:0] lead;
        acc_t [LANES-1:0] trail;
        acc_t [LANES-1:0] tail;
        logic             vld2;
        acc_t [LANES-1:0] y;
    } state_t;
endpackage

// File: rtl/blkfir_mcm.sv
module blkfir_mcm
    import blkfir_pkg::*;
(
    input  smp_t smp,
    output acc_t m3,
    output acc_t m5,
    output acc_t m18,
    output acc_t m44
);
    acc_t x, x8, x9, x11;

    always_comb begin
        x   = {{(AW-SW){smp[SW-1]}}, smp};
        x8  = x <<< 3;
        m3  = (x <<< 1) + x;
        m5  = (x <<< 2) + x;
        x9  = x8 + x;
        x11 = x8 + m3;
        m18 = x9 <<< 1;
        m44 = x11 <<< 2;
    end
endmodule

// File: rtl/blkfir_row.sv
module blkfir_row
    import blkfir_pkg::*;
(
    input  acc_t a44,
    input  acc_t a3,
    input  acc_t b18,
    input  acc_t b5,
    input  acc_t c5,
    input  acc_t c18,
    input  acc_t d3,
    input  acc_t d44,
    output acc_t lead,
    output acc_t trail
);
    acc_t lead_hi, lead_lo, trail_hi, trail_lo;

    always_comb begin
        lead_hi  = a44 + b18;
        lead_lo  = c5 - d3;
        trail_hi = d44 + c18;
        trail_lo = b5 - a3;
        lead     = lead_hi + lead_lo;
        trail    = trail_hi + trail_lo;
    end
endmodule

// File: rtl/blkfir_top.sv
module blkfir_top
    import blkfir_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [LANES*SW-1:0] in_blk,
    output logic                out_vld,
    output logic [LANES*AW-1:0] out_blk
);
    state_t q, d;

    smp_t lane  [LANES];
    smp_t win_s [WIN];
    acc_t m3  [WIN];
    acc_t m5  [WIN];
    acc_t m18 [WIN];
    acc_t m44 [WIN];
    acc_t lead_w  [LANES];
    acc_t trail_w [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane[j] = in_blk[j*SW +: SW];
        assign win_s[j + LANES - 1] = lane[j];
    end

    for (genvar n = 0; n < LANES - 1; n++) begin : g_hist
        assign win_s[n] = q.hist[n];
    end

    for (genvar n = 0; n < WIN; n++) begin : g_mcm
        blkfir_mcm u_mcm (
            .smp (win_s[n]),
            .m3  (m3[n]),
            .m5  (m5[n]),
            .m18 (m18[n]),
            .m44 (m44[n])
        );
    end

    for (genvar j = 0; j < LANES; j++) begin : g_row
        blkfir_row u_row (
            .a44   (m44[j]),
            .a3    (m3[j]),
            .b18   (m18[j+1]),
            .b5    (m5[j+1]),
            .c5    (m5[j+2]),
            .c18   (m18[j+2]),
            .d3    (m3[j+3]),
            .d44   (m44[j+3]),
            .lead  (lead_w[j]),
            .trail (trail_w[j])
        );
    end

    always_comb begin
        d      = q;
        d.vld1 = in_vld;
        d.vld2 = q.vld1;
        if (in_vld) begin
            for (int n = 0; n < LANES - 1; n++) begin
                d.hist[n] = lane[n+1];
            end
            for (int j = 0; j < LANES; j++) begin
                d.lead[j]  = lead_w[j];
                d.trail[j] = trail_w[j];
            end
        end
        if (q.vld1) begin
            for (int j = 0; j < LANES; j++) begin
                d.y[j]    = q.lead[j] + q.tail[j];
                d.tail[j] = q.trail[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_vld = q.vld2;
    assign out_blk = q.y;
endmodule

// File: rtl/blkfir_chk.sv
module blkfir_chk
    import blkfir_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_vld,
    input logic                out_vld,
    input logic [LANES*AW-1:0] out_blk
);
    localparam int LIM = HABS * (1 << (SW - 1));

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> ##2 out_vld); // R1

    AST_VLD_SOURCE: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(in_vld, 2)); // R1

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> $stable(out_blk)); // R6

    always_ff @(posedge clk) begin
        if (rst_q && !rst) begin
            AST_RST_CLEAR: assert (!out_vld && out_blk == '0); // R7
        end
        if (!rst && out_vld) begin
            for (int j = 0; j < LANES; j++) begin
                AST_NO_OVERFLOW: assert ($signed(out_blk[j*AW +: AW]) <= LIM &&
                                         $signed(out_blk[j*AW +: AW]) >= -LIM); // R3
            end
        end
    end
endmodule

bind blkfir_top blkfir_chk u_chk (.*);

// File: tb/sim_blkfir_top.sv
module sim_blkfir_top;
    import blkfir_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_vld = 1'b0;
    logic [LANES*SW-1:0] in_blk = '0;
    logic                out_vld;
    logic [LANES*AW-1:0] out_blk;

    int coef [NTAP] = '{-3, 5, 18, 44, 44, 18, 5, -3};
    int mhist [NTAP-1];
    int expq [0:1023][LANES];
    int wr = 0;
    int rd = 0;
    int nchk = 0;
    int nfail = 0;
    string req = "R7";

    blkfir_top u0 (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .in_blk  (in_blk),
        .out_vld (out_vld),
        .out_blk (out_blk)
    );

    always #4 clk = ~clk;

    function automatic int lane_out(int j);
        return int'($signed(out_blk[j*AW +: AW]));
    endfunction

    function automatic int rnd_smp();
        return int'($urandom_range(4095)) - 2048;
    endfunction

    task automatic check(string r, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NTAP - 1; i++) mhist[i] = 0;
    endtask

    task automatic send(int x0, int x1, int x2, int x3);
        int xs [LANES];
        xs[0] = x0; xs[1] = x1; xs[2] = x2; xs[3] = x3;
        @(negedge clk);
        in_vld = 1'b1;
        for (int j = 0; j < LANES; j++) begin
            int acc;
            in_blk[j*SW +: SW] = SW'(xs[j]);
            acc = coef[0] * xs[j];
            for (int i = 1; i < NTAP; i++) acc += coef[i] * mhist[i-1];
            for (int i = NTAP - 2; i > 0; i--) mhist[i] = mhist[i-1];
            mhist[0] = xs[j];
            expq[wr][j] = acc;
        end
        wr++;
    endtask

    task automatic idle(int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            in_vld = 1'b0;
            for (int j = 0; j < LANES; j++) in_blk[j*SW +: SW] = SW'(rnd_smp());
        end
    endtask

    task automatic drain(string r);
        idle(4);
        check(r, "blocks out vs blocks in", rd, wr);
    endtask

    always @(negedge clk) begin
        if (!rst && out_vld) begin
            if (rd >= wr) begin
                check("R1", "unexpected output block", 1, 0);
            end else begin
                for (int j = 0; j < LANES; j++) begin
                    check(req, $sformatf("block %0d lane %0d", rd, j), lane_out(j), expq[rd][j]);
                end
                rd++;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        check("R7", "out_vld after reset", int'(out_vld), 0);
        for (int j = 0; j < LANES; j++) check("R7", "out lane after reset", lane_out(j), 0);
    endtask

    task automatic t_latency();
        req = "R1";
        send(1, 2, 3, 4);
        idle(1);
        check("R1", "out_vld one cycle after strobe", int'(out_vld), 0);
        idle(1);
        check("R1", "out_vld two cycles after strobe", int'(out_vld), 1);
        idle(1);
        check("R1", "out_vld three cycles after strobe", int'(out_vld), 0);
        drain("R1");
    endtask

    task automatic t_impulse();
        req = "R2";
        do_reset();
        send(1, 0, 0, 0);
        send(0, 0, 0, 0);
        send(0, 0, 0, 0);
        drain("R2");
        req = "R4";
        send(0, 0, 0, 1);
        send(0, 0, 0, 0);
        send(0, 0, 0, 0);
        drain("R4");
    endtask

    task automatic t_random();
        req = "R4";
        for (int b = 0; b < 40; b++) send(rnd_smp(), rnd_smp(), rnd_smp(), rnd_smp());
        drain("R4");
    endtask

    task automatic t_stall();
        req = "R5";
        for (int b = 0; b < 30; b++) begin
            send(rnd_smp(), rnd_smp(), rnd_smp(), rnd_smp());
            idle(1 + int'($urandom_range(2)));
        end
        drain("R5");
    endtask

    task automatic t_hold();
        logic [LANES*AW-1:0] snap;
        req = "R6";
        send(100, -200, 300, -400);
        idle(2);
        check("R6", "out_vld for held block", int'(out_vld), 1);
        snap = out_blk;
        for (int c = 0; c < 5; c++) begin
            idle(1);
            check("R6", "out_vld low while idle", int'(out_vld), 0);
            for (int j = 0; j < LANES; j++) begin
                check("R6", "held lane", lane_out(j), int'($signed(snap[j*AW +: AW])));
            end
        end
        drain("R6");
    endtask

    task automatic t_extreme();
        req = "R3";
        for (int b = 0; b < 3; b++) send(-2048, -2048, -2048, -2048);
        for (int b = 0; b < 3; b++) send(2047, 2047, 2047, 2047);
        for (int b = 0; b < 4; b++) send(-2048, 2047, 2047, -2048);
        for (int b = 0; b < 4; b++) send(2047, -2048, -2048, 2047);
        drain("R3");
    endtask

    task automatic t_midreset();
        req = "R7";
        for (int b = 0; b < 3; b++) send(2047, -2048, 1500, -999);
        drain("R7");
        do_reset();
        send(0, 7, 0, 0);
        send(0, 0, 0, 0);
        drain("R7");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog expired: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();
        t_latency();
        t_impulse();
        t_random();
        t_stall();
        t_hold();
        t_extreme();
        t_midreset();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule